// File: doc/BRIEF.md
# Split-Transaction Sequencer for Queue Heads

This block drives the start-split / complete-split exchange for one queue head that targets a full-speed or low-speed bulk or control endpoint reached through a high-speed hub's transaction translator. Software-side logic loads the queue-head fields once: endpoint speed, device address, hub address, hub port, control flag and error budget. After that, the sequencer presents the next token to send on the high-speed bus. It also keeps the queue-head status up to date from the handshake result of each bus attempt.

The sequencer keeps the split phase bit, the error budget, the active and halted flags, and the transaction-error flag. It also emits two one-cycle indications. The first asks for an immediate retry of the complete-split. The second marks a finished transaction. High-speed queue heads pass through without split wrapping. For them, only the stall and error-budget handling applies.

Top module: `split_seq_top`

## Requirements
- R1: After reset, `st_active`, `st_halted`, `st_xact_err`, `tok_valid`, `retry_now` and `xfer_done` are 0, `st_cerr` is 0, and `tok_complete` is 0.
- R2: A `load` pulse captures all queue-head fields and, on that edge, makes the head active and not halted, clears `st_xact_err`, sets the phase to start-split (`tok_complete`=0) and sets `st_cerr` to `ld_cerr`. `tok_valid` equals `st_active`.
- R3: While `tok_valid` is 1, the token fields follow the loaded queue head. `tok_split` is 1 exactly when the speed is full (2'b00) or low (2'b01); 2'b10 and 2'b11 mean high speed. `tok_low_speed` is 1 for speed 2'b01. `tok_ep_type` is 2'b00 (control) when the control flag is 1 and 2'b10 (bulk) when it is 0. `tok_hub_addr`, `tok_port` and `tok_dev_addr` carry the loaded values.
- R4: Result codes are ACK=0, NAK=1, NYET=2, STALL=3 and XACTERR=4. In the start-split phase of a split head, ACK moves to the complete-split phase, while NAK and NYET leave the phase unchanged.
- R5: In the complete-split phase, NYET keeps the phase and raises `retry_now` for one cycle.
- R6: XACTERR lowers a non-zero `st_cerr` by one in either phase. In the complete-split phase it also sets `st_xact_err` and, unless the head halts, raises `retry_now`.
- R7: An XACTERR that takes `st_cerr` from 1 to 0 sets `st_halted`, clears `st_active` and raises no retry.
- R8: STALL in either phase sets `st_halted` and clears `st_active`.
- R9: In the complete-split phase, ACK returns the phase to start-split and raises `xfer_done` for one cycle.
- R10: A head loaded with `ld_cerr`=0 never has its count lowered and never halts on XACTERR.
- R11: In the complete-split phase, NAK returns the phase to start-split and leaves `st_cerr` unchanged.
- R12: A result is ignored while the head is inactive, when `load` is asserted on the same edge, or when its code is 5, 6 or 7.
- R13: On a high-speed head, the phase stays start-split and ACK raises `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load queue-head fields |
| ld_speed | input | 2 | Endpoint speed: 00 full, 01 low, 1x high |
| ld_dev_addr | input | ADDR_W | Endpoint device address |
| ld_hub_addr | input | ADDR_W | Hub device address |
| ld_port | input | PORT_W | Hub port of the translator |
| ld_ctrl | input | 1 | 1 for a control endpoint |
| ld_cerr | input | CERR_W | Error budget, 0 = unlimited |
| res_valid | input | 1 | Handshake result strobe |
| res_code | input | 3 | Handshake result code |
| tok_valid | output | 1 | A token is to be issued |
| tok_split | output | 1 | Token is split-wrapped |
| tok_complete | output | 1 | 1 complete-split, 0 start-split |
| tok_low_speed | output | 1 | Endpoint is low speed |
| tok_ep_type | output | 2 | Split endpoint type: 00 control, 10 bulk |
| tok_dev_addr | output | ADDR_W | Endpoint device address |
| tok_hub_addr | output | ADDR_W | Hub address of the split token |
| tok_port | output | PORT_W | Hub port of the split token |
| st_active | output | 1 | Queue head active |
| st_halted | output | 1 | Queue head halted |
| st_xact_err | output | 1 | Transaction error seen in complete-split |
| st_cerr | output | CERR_W | Remaining error budget |
| retry_now | output | 1 | Reissue the complete-split at once |
| xfer_done | output | 1 | Transaction finished |

## Verification
Directed sequences first walk one control head through each result in each phase. This separates the phase-dependent meaning of NAK, NYET and XACTERR, which behave differently in start-split and in complete-split. Further directed heads set the error budget to one, zero and three. They show whether a decrement halts the head, leaves it running without limit, or only reduces the count. A high-speed head shows that ACK completes without a phase change.

A seeded random stream then mixes reloads, stalls, invalid codes and results that arrive while the head is inactive or on the same edge as a load. Every output is compared each cycle with a bench model. The stream catches wrong precedence between load and result, and wrong gating on the active flag.

// File: rtl/split_seq_pkg.sv
package split_seq_pkg;
   typedef enum logic [2:0] {
      HS_ACK   = 3'd0,
      HS_NAK   = 3'd1,
      HS_NYET  = 3'd2,
      HS_STALL = 3'd3,
      HS_XERR  = 3'd4
   } hshake_e;

   typedef enum logic {
      PH_START    = 1'b0,
      PH_COMPLETE = 1'b1
   } phase_e;

   localparam logic [1:0] SPD_FULL   = 2'b00;
   localparam logic [1:0] SPD_LOW    = 2'b01;
   localparam logic [1:0] ET_CONTROL = 2'b00;
   localparam logic [1:0] ET_BULK    = 2'b10;
endpackage

// File: rtl/split_err_budget.sv
module split_err_budget #(
   parameter int CERR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CERR_W-1:0] ld_cerr,
   input  logic              dec,
   output logic [CERR_W-1:0] cerr,
   output logic              spent
);
   localparam logic [CERR_W-1:0] ONE = CERR_W'(1);

   // a zero count means unlimited: only a count of one can be spent
   assign spent = dec && (cerr == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cerr <= '0;
      else if (load)
         cerr <= ld_cerr;
      else if (dec && (cerr != '0))
         cerr <= cerr - ONE;
   end

   // R6
   cerr_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cerr <= $past(cerr)));

   // R10
   unlimited_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cerr == '0) |=> (cerr == '0));
endmodule

// File: rtl/split_phase_fsm.sv
module split_phase_fsm
   import split_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  logic    res_valid,
   input  logic [2:0] res_code,
   input  logic    is_split,
   input  logic    spent,
   output logic    dec,
   output logic    active,
   output logic    halted,
   output phase_e  phase,
   output logic    xact_err,
   output logic    retry,
   output logic    done
);
   logic    acc;
   hshake_e res;

   assign res = hshake_e'(res_code);
   assign acc = res_valid && active && !load;
   assign dec = acc && (res == HS_XERR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         halted   <= 1'b0;
         phase    <= PH_START;
         xact_err <= 1'b0;
         retry    <= 1'b0;
         done     <= 1'b0;
      end else begin
         retry <= 1'b0;
         done  <= 1'b0;
         if (load) begin
            active   <= 1'b1;
            halted   <= 1'b0;
            phase    <= PH_START;
            xact_err <= 1'b0;
         end else if (acc) begin
            case (res)
               HS_ACK: begin
                  if (is_split && phase == PH_START)
                     phase <= PH_COMPLETE;
                  else begin
                     phase <= PH_START;
                     done  <= 1'b1;
                  end
               end
               HS_NAK:  phase <= PH_START;
               HS_NYET: if (phase == PH_COMPLETE) retry <= 1'b1;
               HS_STALL: begin
                  halted <= 1'b1;
                  active <= 1'b0;
               end
               HS_XERR: begin
                  if (spent) begin
                     halted <= 1'b1;
                     active <= 1'b0;
                  end
                  if (is_split && phase == PH_COMPLETE) begin
                     xact_err <= 1'b1;
                     retry    <= !spent;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R8
   halted_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !active);

   // R8
   stall_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && res == HS_STALL) |=> (halted && !active));

   // R5
   retry_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> (phase == PH_COMPLETE && active));

   // R9
   done_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase == PH_START));

   // R13
   hs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_split |-> (phase == PH_START));
endmodule

// File: rtl/split_token_build.sv
module split_token_build
   import split_seq_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int PORT_W    = 7,
   parameter bit REG_TOKEN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  phase_e            phase,
   input  logic [1:0]        speed,
   input  logic              ctrl,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [ADDR_W-1:0] hub_addr,
   input  logic [PORT_W-1:0] port,
   output logic              tok_valid,
   output logic              tok_split,
   output logic              tok_complete,
   output logic              tok_low_speed,
   output logic [1:0]        tok_ep_type,
   output logic [ADDR_W-1:0] tok_dev_addr,
   output logic [ADDR_W-1:0] tok_hub_addr,
   output logic [PORT_W-1:0] tok_port
);
   localparam int TOK_W = 5 + 2 + 2 * ADDR_W + PORT_W;

   logic [TOK_W-1:0] nxt, cur;
   logic             split_c;

   assign split_c = (speed == SPD_FULL) || (speed == SPD_LOW);
   assign nxt = {active, split_c, (phase == PH_COMPLETE), (speed == SPD_LOW),
                 1'b0, (ctrl ? ET_CONTROL : ET_BULK), dev_addr, hub_addr, port};

   generate
      if (REG_TOKEN) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) cur <= '0;
            else        cur <= nxt;
         end
      end else begin : g_comb
         assign cur = nxt;
      end
   endgenerate

   logic unused_pad;
   assign {tok_valid, tok_split, tok_complete, tok_low_speed, unused_pad,
           tok_ep_type, tok_dev_addr, tok_hub_addr, tok_port} = cur;
endmodule

// File: rtl/split_seq_top.sv
module split_seq_top
   import split_seq_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int PORT_W    = 7,
   parameter int CERR_W    = 2,
   parameter bit REG_TOKEN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        ld_speed,
   input  logic [ADDR_W-1:0] ld_dev_addr,
   input  logic [ADDR_W-1:0] ld_hub_addr,
   input  logic [PORT_W-1:0] ld_port,
   input  logic              ld_ctrl,
   input  logic [CERR_W-1:0] ld_cerr,
   input  logic              res_valid,
   input  logic [2:0]        res_code,
   output logic              tok_valid,
   output logic              tok_split,
   output logic              tok_complete,
   output logic              tok_low_speed,
   output logic [1:0]        tok_ep_type,
   output logic [ADDR_W-1:0] tok_dev_addr,
   output logic [ADDR_W-1:0] tok_hub_addr,
   output logic [PORT_W-1:0] tok_port,
   output logic              st_active,
   output logic              st_halted,
   output logic              st_xact_err,
   output logic [CERR_W-1:0] st_cerr,
   output logic              retry_now,
   output logic              xfer_done
);
   generate
      if (ADDR_W < 1 || PORT_W < 1) begin : g_bad_addr
         $error("split_seq_top: address and port widths must be positive");
      end
      if (CERR_W < 1 || CERR_W > 8) begin : g_bad_cerr
         $error("split_seq_top: CERR_W must lie in 1..8");
      end
   endgenerate

   logic [1:0]        qh_speed;
   logic              qh_ctrl;
   logic [ADDR_W-1:0] qh_dev, qh_hub;
   logic [PORT_W-1:0] qh_port;
   logic              is_split, dec, spent;
   phase_e            phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qh_speed <= '0;
         qh_ctrl  <= 1'b0;
         qh_dev   <= '0;
         qh_hub   <= '0;
         qh_port  <= '0;
      end else if (load) begin
         qh_speed <= ld_speed;
         qh_ctrl  <= ld_ctrl;
         qh_dev   <= ld_dev_addr;
         qh_hub   <= ld_hub_addr;
         qh_port  <= ld_port;
      end
   end

   assign is_split = !qh_speed[1];

   split_err_budget #(.CERR_W(CERR_W)) u_budget (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_cerr(ld_cerr),
      .dec(dec), .cerr(st_cerr), .spent(spent)
   );

   split_phase_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .load(load), .res_valid(res_valid),
      .res_code(res_code), .is_split(is_split), .spent(spent), .dec(dec),
      .active(st_active), .halted(st_halted), .phase(phase),
      .xact_err(st_xact_err), .retry(retry_now), .done(xfer_done)
   );

   split_token_build #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .REG_TOKEN(REG_TOKEN)) u_tok (
      .clk(clk), .rst_n(rst_n), .active(st_active), .phase(phase),
      .speed(qh_speed), .ctrl(qh_ctrl), .dev_addr(qh_dev), .hub_addr(qh_hub),
      .port(qh_port), .tok_valid(tok_valid), .tok_split(tok_split),
      .tok_complete(tok_complete), .tok_low_speed(tok_low_speed),
      .tok_ep_type(tok_ep_type), .tok_dev_addr(tok_dev_addr),
      .tok_hub_addr(tok_hub_addr), .tok_port(tok_port)
   );

   // R7
   budget_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && res_valid && st_active && res_code == 3'd4 && st_cerr == CERR_W'(1))
      |=> (st_halted && !retry_now));
endmodule

// File: tb/split_seq_top_test.sv
`timescale 1ns/1ps
module split_seq_top_test;
   localparam int AW = 7, PW = 7, CW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic load = 1'b0, ld_ctrl = 1'b0, res_valid = 1'b0;
   logic [1:0] ld_speed = '0;
   logic [AW-1:0] ld_dev_addr = '0, ld_hub_addr = '0;
   logic [PW-1:0] ld_port = '0;
   logic [CW-1:0] ld_cerr = '0;
   logic [2:0] res_code = '0;
   logic tok_valid, tok_split, tok_complete, tok_low_speed;
   logic [1:0] tok_ep_type;
   logic [AW-1:0] tok_dev_addr, tok_hub_addr;
   logic [PW-1:0] tok_port;
   logic st_active, st_halted, st_xact_err, retry_now, xfer_done;
   logic [CW-1:0] st_cerr;

   always #2.5 clk = ~clk;

   split_seq_top uut (.*);

   int checks = 0, errors = 0;

   // bench model of the queue head
   logic m_active = 0, m_halted = 0, m_comp = 0, m_xerr = 0, m_retry = 0, m_done = 0;
   int   m_cerr = 0;
   logic [1:0] m_speed = 0;
   logic m_ctrl = 0;
   int   m_dev = 0, m_hub = 0, m_port = 0;

   function automatic logic split_of(logic [1:0] s);
      return (s == 2'b00) || (s == 2'b01);
   endfunction

   function automatic int et_of(logic c);
      return c ? 0 : 2;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, "active", st_active, m_active);
      check(tag, "halted", st_halted, m_halted);
      check(tag, "xact_err", st_xact_err, m_xerr);
      check(tag, "cerr", st_cerr, m_cerr);
      check(tag, "retry", retry_now, m_retry);
      check(tag, "done", xfer_done, m_done);
      check(tag, "tok_valid", tok_valid, m_active);
      if (m_active) begin
         check(tag, "complete", tok_complete, m_comp);
         check(tag, "split", tok_split, split_of(m_speed));
         check(tag, "low", tok_low_speed, m_speed == 2'b01);
         check(tag, "ep_type", tok_ep_type, et_of(m_ctrl));
         check(tag, "dev", tok_dev_addr, m_dev);
         check(tag, "hub", tok_hub_addr, m_hub);
         check(tag, "port", tok_port, m_port);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare at next negedge
   task automatic step(string tag, logic ld, logic [1:0] spd, logic ctl, int dev, int hub,
                       int prt, int cerr, logic rv, logic [2:0] code);
      @(negedge clk);
      load = ld; ld_speed = spd; ld_ctrl = ctl; ld_dev_addr = AW'(dev);
      ld_hub_addr = AW'(hub); ld_port = PW'(prt); ld_cerr = CW'(cerr);
      res_valid = rv; res_code = code;
      m_retry = 0; m_done = 0;
      if (ld) begin
         m_active = 1; m_halted = 0; m_comp = 0; m_xerr = 0; m_cerr = cerr;
         m_speed = spd; m_ctrl = ctl; m_dev = dev; m_hub = hub; m_port = prt;
      end else if (rv && m_active) begin
         case (code)
            3'd0: if (split_of(m_speed) && !m_comp) m_comp = 1;
                  else begin m_comp = 0; m_done = 1; end
            3'd1: m_comp = 0;
            3'd2: if (m_comp) m_retry = 1;
            3'd3: begin m_halted = 1; m_active = 0; end
            3'd4: begin
               logic halt_now;
               halt_now = (m_cerr == 1);
               if (m_cerr != 0) m_cerr--;
               if (halt_now) begin m_halted = 1; m_active = 0; end
               if (m_comp) begin m_xerr = 1; m_retry = !halt_now; end
            end
            default: ;
         endcase
      end
      @(negedge clk);
      load = 0; res_valid = 0;
      #0;
      compare_all(tag);
   endtask

   task automatic res(string tag, logic [2:0] code);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 1, code);
   endtask

   task automatic ld(string tag, logic [1:0] spd, logic ctl, int dev, int hub, int prt, int cerr);
      step(tag, 1, spd, ctl, dev, hub, prt, cerr, 0, 0);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare_all("R1 reset");
      check("R1", "tok_complete", tok_complete, 0);

      // control head, full speed, budget 3
      ld("R2 R3 load control", 2'b00, 1, 12, 34, 5, 3);
      res("R4 start NAK stays", 3'd1);
      res("R4 start NYET stays", 3'd2);
      res("R4 start ACK to complete", 3'd0);
      res("R5 complete NYET retry", 3'd2);
      res("R6 complete XACTERR", 3'd4);
      res("R11 complete NAK to start", 3'd1);
      res("R6 start XACTERR", 3'd4);
      res("R4 ACK", 3'd0);
      res("R9 complete ACK done", 3'd0);
      res("R12 invalid code", 3'd6);

      // low-speed bulk head, budget 1
      ld("R3 load bulk low", 2'b01, 0, 99, 7, 120, 1);
      res("R4 ACK", 3'd0);
      res("R7 budget spent halts", 3'd4);
      res("R12 ignored while halted", 3'd0);

      // unlimited budget
      ld("R10 load unlimited", 2'b00, 0, 1, 2, 3, 0);
      res("R4 ACK", 3'd0);
      for (int i = 0; i < 5; i++) res("R10 XACTERR unlimited", 3'd4);
      res("R8 STALL in complete", 3'd3);

      // high speed head
      ld("R13 load high speed", 2'b10, 1, 5, 6, 7, 2);
      res("R13 ACK done no phase", 3'd0);
      res("R8 STALL in start", 3'd3);

      // load wins over simultaneous result
      step("R12 load beats result", 1, 2'b00, 1, 3, 4, 9, 2, 1, 3'd3);

      // random stream
      for (int i = 0; i < 1500; i++) begin
         int r = $urandom % 16;
         if (r == 0 || (!m_active && r < 6))
            step("R2 R12 random load", 1, 2'($urandom), 1'($urandom), $urandom % 128,
                 $urandom % 128, $urandom % 128, $urandom % 4, 1'($urandom), 3'($urandom % 8));
         else
            step("R4 R5 R6 R7 R8 R9 R11 random result", 0, 0, 0, 0, 0, 0, 0,
                 ($urandom % 8) != 0, 3'($urandom % 6));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule